// File: doc/BRIEF.md
# Paged nibble-wide data RAM

This block is the 4-bit data store of a small microcontroller core. A single-cycle CPU bus reaches two address spaces, chosen by a space-select input. The direct space holds one fixed bank of 64 nibbles and also holds a 2-bit page register. The indirect space is a 64-nibble window. The page register picks which of four physical 64-nibble pages sits behind that window.

Software switches the page by writing the page register, and can read the register back. Reads are registered, so read data appears one clock after the read strobe. The bus carries no halt or retention control. Contents simply stay as they are whenever the bus is idle, which covers the core's halted state.

Top module: `paged_nibble_ram`

## Requirements
- R1: With `ind_i`=0 and an address from 0 to 63, a write stores `wdata_i` in the direct bank, and a later read of the same address returns it. All 64 locations are independent.
- R2: With `ind_i`=1 and an address from 0 to 63, the access goes to that index in the page that the page register currently selects. A write leaves the same index in the other three pages unchanged.
- R3: With `ind_i`=0, address 0x77 is the page register. Bits 1..0 are written from `wdata_i[1:0]` and read back. Bits 3..2 always read 0, and writing them has no effect.
- R4: After reset, the page register is 0 (page 0), `rdata_o` is 0, and every direct and paged location reads 0.
- R5: A read strobe sampled at a clock edge puts the addressed value on `rdata_o` after that edge. Without a read strobe, `rdata_o` holds its last value.
- R6: A read issued in the cycle right after a page-register write uses the newly written page.
- R7: Any address outside 0..63 is ignored on writes and reads 0. The one exception is direct-space address 0x77. A write there leaves every other location in every space unchanged, including the location that the low six address bits would name.
- R8: A read and a write to the same location in the same cycle return the value from before the write. The written value is visible to later reads.
- R9: While neither strobe is active, no location, no page-register bit and no `rdata_o` bit changes, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Nibble address within the selected space |
| ind_i | input | 1 | Space select: 0 direct/register, 1 paged window |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Registered read data |

## Verification
Some rules are checked by assertions on every cycle:
- `rdata_o` holds when no read strobe is present.
- The page register changes only on a write to 0x77 and then takes the written low bits.
- Out-of-range reads return 0 and the upper register bits read 0.
- Reset leaves page 0 and zero read data.

Other behaviour needs state carried across many cycles, so only the bench's scenarios show it:
- The page actually steering the window.
- A paged write leaving the other three pages alone.
- Out-of-range writes not aliasing onto low addresses.
- Read-before-write ordering.
- Retention over long idle stretches.

// File: rtl/pgram_pkg.sv
package pgram_pkg;

    // Which storage element an access lands on
    typedef enum logic [1:0] {
        TGT_NONE    = 2'd0,
        TGT_DIRECT  = 2'd1,
        TGT_PAGED   = 2'd2,
        TGT_PAGEREG = 2'd3
    } tgt_e;

    localparam int unsigned NIB_W      = 4;
    localparam int unsigned BUS_AW     = 8;
    localparam int unsigned BANK_DEPTH = 64;
    localparam int unsigned NUM_PAGES  = 4;

endpackage

// File: rtl/pgram_decode.sv
module pgram_decode
    import pgram_pkg::*;
#(
    parameter int unsigned AW       = BUS_AW,
    parameter int unsigned DEPTH    = BANK_DEPTH,
    parameter logic [AW-1:0] REG_ADDR = 8'h77,
    localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             ind_i,
    output tgt_e             tgt_o,
    output logic [IDX_W-1:0] idx_o
);

    logic in_range;

    always_comb begin
        in_range = (addr_i[AW-1:IDX_W] == '0);
        idx_o    = addr_i[IDX_W-1:0];
        if (in_range) begin
            tgt_o = ind_i ? TGT_PAGED : TGT_DIRECT;
        end else if (!ind_i && addr_i == REG_ADDR) begin
            tgt_o = TGT_PAGEREG;
        end else begin
            tgt_o = TGT_NONE;
        end
    end

endmodule

// File: rtl/pgram_bank.sv
module pgram_bank #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.mem[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Combinational read of the stored (pre-write) contents
    assign rdata_o = st_q.mem[idx_i];

endmodule

// File: rtl/pgram_pagereg.sv
module pgram_pagereg #(
    parameter int unsigned PW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [PW-1:0] wpage_i,
    output logic [PW-1:0] page_o
);

    typedef struct packed {
        logic [PW-1:0] page;
    } preg_st_t;

    preg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.page = wpage_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_o = st_q.page;

endmodule

// File: rtl/paged_nibble_ram.sv
module paged_nibble_ram
    import pgram_pkg::*;
#(
    parameter int unsigned DW       = NIB_W,
    parameter int unsigned AW       = BUS_AW,
    parameter int unsigned DEPTH    = BANK_DEPTH,
    parameter int unsigned PAGES    = NUM_PAGES,
    parameter logic [AW-1:0] REG_ADDR = 8'h77,
    localparam int unsigned IDX_W   = $clog2(DEPTH),
    localparam int unsigned PW      = $clog2(PAGES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          ind_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_st_t;

    tgt_e             tgt;
    logic [IDX_W-1:0] idx;
    logic [PW-1:0]    page_q;
    logic [DW-1:0]    direct_rd;
    logic [DW-1:0]    paged_rd [PAGES];
    logic [DW-1:0]    window_rd;
    logic             wr_direct, wr_paged, wr_page;
    rd_st_t           st_d, st_q;

    pgram_decode #(
        .AW       (AW),
        .DEPTH    (DEPTH),
        .REG_ADDR (REG_ADDR)
    ) u_decode (
        .addr_i (addr_i),
        .ind_i  (ind_i),
        .tgt_o  (tgt),
        .idx_o  (idx)
    );

    assign wr_direct = wr_i && (tgt == TGT_DIRECT);
    assign wr_paged  = wr_i && (tgt == TGT_PAGED);
    assign wr_page   = wr_i && (tgt == TGT_PAGEREG);

    pgram_pagereg #(
        .PW (PW)
    ) u_pagereg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_page),
        .wpage_i (wdata_i[PW-1:0]),
        .page_o  (page_q)
    );

    pgram_bank #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_direct (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_direct),
        .idx_i   (idx),
        .wdata_i (wdata_i),
        .rdata_o (direct_rd)
    );

    for (genvar g = 0; g < PAGES; g++) begin : g_page
        pgram_bank #(
            .DEPTH (DEPTH),
            .DW    (DW)
        ) u_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .we_i    (wr_paged && (page_q == PW'(g))),
            .idx_i   (idx),
            .wdata_i (wdata_i),
            .rdata_o (paged_rd[g])
        );
    end

    assign window_rd = paged_rd[page_q];

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            case (tgt)
                TGT_DIRECT:  st_d.rdata = direct_rd;
                TGT_PAGED:   st_d.rdata = window_rd;
                TGT_PAGEREG: st_d.rdata = DW'(page_q);
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/pgram_checker.sv
module pgram_checker #(
    parameter int unsigned DW       = 4,
    parameter int unsigned AW       = 8,
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned PW       = 2,
    parameter logic [AW-1:0] REG_ADDR = 8'h77,
    localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [AW-1:0] addr_i,
    input logic          ind_i,
    input logic          rd_i,
    input logic          wr_i,
    input logic [PW-1:0] wpage_i,
    input logic [DW-1:0] rdata_o,
    input logic [PW-1:0] page_q
);

    logic reg_hit, out_of_range;
    assign reg_hit      = !ind_i && (addr_i == REG_ADDR);
    assign out_of_range = (addr_i[AW-1:IDX_W] != '0) && !reg_hit;

    // R4: reset leaves page 0 and zero read data
    assert_reset_state_R4: assert property (@(posedge clk_i)
        !rst_ni |=> (page_q == '0 && rdata_o == '0));

    // R5: read data holds without a read strobe
    assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o));

    // R3: a register write loads the low data bits
    assert_page_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && reg_hit) |=> (page_q == $past(wpage_i)));

    // R9: page register is stable without a register write
    assert_page_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && reg_hit) |=> $stable(page_q));

    // R3: register readback has zero upper bits and shows the page
    assert_reg_readback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !wr_i && reg_hit) |=> (rdata_o == DW'($past(page_q))));

    // R7: out-of-range reads return zero
    assert_oor_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && out_of_range) |=> (rdata_o == '0));

endmodule

bind paged_nibble_ram pgram_checker #(
    .DW       (DW),
    .AW       (AW),
    .DEPTH    (DEPTH),
    .PW       (PW),
    .REG_ADDR (REG_ADDR)
) u_pgram_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .ind_i   (ind_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wpage_i (wdata_i[PW-1:0]),
    .rdata_o (rdata_o),
    .page_q  (page_q)
);

// File: tb/paged_nibble_ram_bench.sv
module paged_nibble_ram_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       ind = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;

    always #2 clk = ~clk;   // 250 MHz

    paged_nibble_ram u_paged_nibble_ram (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .ind_i   (ind),
        .rd_i    (rd),
        .wr_i    (wr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );

    typedef struct {
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t       sbq[$];
    int         vectors = 0;
    int         miscmp = 0;
    bit         done = 1'b0;
    bit         rd_seen = 1'b0;
    logic [3:0] last_exp = '0;

    // Reference model built from the requirements
    logic [3:0] m_dir [64];
    logic [3:0] m_pg  [4][64];
    logic [1:0] m_page;

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_rd(input bit i, input logic [7:0] a);
        if (a < 64) return i ? m_pg[m_page][a[5:0]] : m_dir[a[5:0]];
        if (!i && a == 8'h77) return {2'b00, m_page};
        return 4'h0;
    endfunction

    task automatic model_wr(input bit i, input logic [7:0] a, input logic [3:0] d);
        if (a < 64) begin
            if (i) m_pg[m_page][a[5:0]] = d;
            else   m_dir[a[5:0]] = d;
        end else if (!i && a == 8'h77) begin
            m_page = d[1:0];
        end
    endtask

    // Driver: one bus cycle per call, expected read results go to the queue
    task automatic access(input bit i, input logic [7:0] a, input bit r, input bit w,
                          input logic [3:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        ind = i; addr = a; rd = r; wr = w; wdata = d;
        if (r) begin
            e.val = model_rd(i, a);
            e.tag = tag;
            sbq.push_back(e);
            last_exp = e.val;
        end
        if (w) model_wr(i, a, d);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pops one expected item per read strobe seen at a clock edge
    always @(posedge clk) rd_seen <= rd && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sbq.size() == 0) begin
                miscmp++;
                $display("FAIL scoreboard: actual read with empty queue expected none");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(e.tag, rdata, e.val);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_dir[i] = '0;
            for (int p = 0; p < 4; p++) m_pg[p][i] = '0;
        end
        m_page = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state
        check("R4 rdata after reset", rdata, 4'h0);
        access(1'b0, 8'h77, 1, 0, 4'h0, "R4 page reg reset");
        access(1'b0, 8'd5,  1, 0, 4'h0, "R4 direct reset");
        access(1'b1, 8'd9,  1, 0, 4'h0, "R4 paged reset");

        // R1: direct bank fill and readback
        for (int i = 0; i < 64; i++) access(1'b0, 8'(i), 0, 1, 4'((i * 7 + 3) & 15), "R1");
        for (int i = 0; i < 64; i++) access(1'b0, 8'(i), 1, 0, 4'h0, "R1 direct readback");

        // R2: fill each page with its own pattern, then read each back
        for (int p = 0; p < 4; p++) begin
            access(1'b0, 8'h77, 0, 1, 4'(p), "R2 select");
            for (int i = 0; i < 64; i++) access(1'b1, 8'(i), 0, 1, 4'((i + 5 * p + 1) & 15), "R2");
        end
        for (int p = 0; p < 4; p++) begin
            access(1'b0, 8'h77, 0, 1, 4'(p), "R2 select");
            for (int i = 0; i < 64; i += 3) access(1'b1, 8'(i), 1, 0, 4'h0, "R2 page readback");
        end
        // R2: write one index in page 2, others keep their value
        access(1'b0, 8'h77, 0, 1, 4'h2, "R2 select");
        access(1'b1, 8'd10, 0, 1, 4'hE, "R2 single write");
        for (int p = 0; p < 4; p++) begin
            access(1'b0, 8'h77, 0, 1, 4'(p), "R2 select");
            access(1'b1, 8'd10, 1, 0, 4'h0, "R2 isolation");
        end

        // R3: upper register bits ignored and read 0
        access(1'b0, 8'h77, 0, 1, 4'hF, "R3 write all ones");
        access(1'b0, 8'h77, 1, 0, 4'h0, "R3 readback masks upper bits");
        access(1'b0, 8'h77, 0, 1, 4'h6, "R3 write");
        access(1'b0, 8'h77, 1, 0, 4'h0, "R3 readback");

        // R6: read right after a page switch uses the new page
        access(1'b0, 8'h77, 0, 1, 4'h1, "R6 switch");
        access(1'b1, 8'd20, 1, 0, 4'h0, "R6 new page used");
        access(1'b0, 8'h77, 0, 1, 4'h3, "R6 switch");
        access(1'b1, 8'd20, 1, 0, 4'h0, "R6 new page used");

        // R7: out-of-range writes ignored, reads zero, no aliasing
        access(1'b0, 8'd64,  0, 1, 4'h9, "R7");
        access(1'b0, 8'd200, 0, 1, 4'h9, "R7");
        access(1'b1, 8'd70,  0, 1, 4'h9, "R7");
        access(1'b1, 8'h77,  0, 1, 4'h9, "R7");
        access(1'b0, 8'd64,  1, 0, 4'h0, "R7 direct oor read");
        access(1'b1, 8'd70,  1, 0, 4'h0, "R7 paged oor read");
        access(1'b1, 8'h77,  1, 0, 4'h0, "R7 paged 0x77 read");
        access(1'b0, 8'd0,   1, 0, 4'h0, "R7 no alias direct");
        access(1'b0, 8'd8,   1, 0, 4'h0, "R7 no alias direct");
        access(1'b1, 8'd6,   1, 0, 4'h0, "R7 no alias paged");
        access(1'b1, 8'd55,  1, 0, 4'h0, "R7 no alias paged");
        access(1'b0, 8'h77,  1, 0, 4'h0, "R7 page unchanged");

        // R8: read and write together return the old value
        access(1'b0, 8'd33, 1, 1, 4'hA, "R8 old value");
        access(1'b0, 8'd33, 1, 0, 4'h0, "R8 new value");
        access(1'b1, 8'd33, 1, 1, 4'h5, "R8 old value paged");
        access(1'b1, 8'd33, 1, 0, 4'h0, "R8 new value paged");

        // R5: read data holds across idle cycles
        access(1'b0, 8'd12, 1, 0, 4'h0, "R5 read");
        idle(6);
        check("R5 hold", rdata, last_exp);

        // R9: long idle, then everything still in place
        idle(40);
        check("R9 rdata idle", rdata, last_exp);
        for (int i = 0; i < 64; i++) access(1'b0, 8'(i), 1, 0, 4'h0, "R9 direct retained");
        for (int i = 0; i < 64; i += 5) access(1'b1, 8'(i), 1, 0, 4'h0, "R9 paged retained");
        access(1'b0, 8'h77, 1, 0, 4'h0, "R9 page retained");
        idle(4);

        if (sbq.size() != 0) begin
            miscmp++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule